// File: doc/BRIEF.md
# LL/SC Reservation Table Controller

This block tracks reservations for linked-load / store-conditional atomics on the memory side of a shared cache. It accepts one command at a time: a linked load, a store-conditional, or a plain write that can cover an inclusive address range. Each command is checked against a small fully associative table. An entry in the table holds a 40-bit physical address, a 32-bit reservation key and a valid bit.

A linked load either returns the key of an existing reservation for the same address, or it takes a fresh key from an internal counter and records a new reservation. When the table is full, the new reservation replaces a victim. A store-conditional succeeds only when both its address and its key match a live reservation. A success consumes the reservation and allows the data write. A plain write always proceeds, and it cancels every reservation whose address lies inside the written range.

The response is a single beat. It carries the key, a status flag and a write-permit bit for the data array.

Top module: `llsc_resv_ctrl`

## Requirements
- R1: After reset no entry is valid, `cmd_ready` is 1 and `rsp_valid` is 0, so any store-conditional issued first fails.
- R2: An accepted command (`cmd_valid` and `cmd_ready` both high at a clock edge) raises `rsp_valid` at that edge. The response holds its value, and `cmd_ready` stays 0, until `rsp_ready` is seen high at a clock edge.
- R3: A linked load (`cmd_op`=0) to an address held by a valid entry returns that entry's key with `rsp_ok`=1 and `rsp_wr_en`=0. It allocates no key, so the next allocation receives the value that would otherwise have been issued.
- R4: A linked load that finds no match records a new valid entry with a fresh key and returns that key. The first key after reset is 1, and each allocation adds 1. Key 0 is never issued.
- R5: A store-conditional (`cmd_op`=1) whose address and `cmd_key` both match a valid entry returns `rsp_ok`=1 and `rsp_wr_en`=1, and it invalidates that entry. A repeat of the same store-conditional therefore fails.
- R6: A store-conditional with no matching entry (wrong key or wrong address) returns `rsp_ok`=0 and `rsp_wr_en`=0 and leaves the table unchanged.
- R7: A plain write (`cmd_op`=2) over `cmd_addr`..`cmd_addr_hi` invalidates every valid entry whose address lies within the range, bounds included. Entries outside the range are left alone. The write returns `rsp_ok`=1 and `rsp_wr_en`=1.
- R8: A new reservation goes into the lowest-indexed invalid entry. When every entry is valid, a round-robin pointer picks the victim. The pointer starts at entry 0 after reset and advances by one after each eviction.
- R9: The reserved op code 3 returns key 0, `rsp_ok`=0 and `rsp_wr_en`=0, and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 linked load, 1 store-conditional, 2 write, 3 reserved |
| cmd_addr | input | 40 | Address X, or the low bound of a write range |
| cmd_addr_hi | input | 40 | High bound of a write range (used by writes only) |
| cmd_key | input | 32 | Key carried by a store-conditional |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_key | output | 32 | Reservation key for a linked load, 0 otherwise |
| rsp_ok | output | 1 | Success status |
| rsp_wr_en | output | 1 | Data array may perform the write |

## Verification
Allocating a new reservation and evicting a victim happen in the same accepted cycle when a linked load misses on a full table. The bench fills all eight entries, then issues further linked loads to new addresses. It judges which reservation was evicted by sending store-conditionals: those carrying the evicted address and key must fail, and those for the surviving entries must succeed. A burst write that cancels several entries in one cycle is judged the same way, including entries that sit exactly on the range bounds.

// File: rtl/llsc_pkg.sv
// Package: shared command encoding for the reservation controller.
// Assumes a 2-bit op field on the command port.
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LL  = 2'd0,
        OP_SC  = 2'd1,
        OP_WR  = 2'd2,
        OP_RSV = 2'd3
    } llsc_op_e;
endpackage

// File: rtl/llsc_match.sv
// Module: parallel comparators over every table entry.
// Produces address-hit, address+key-hit and range-hit vectors.
// Assumes the table never holds two valid entries with the same address.
module llsc_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 40,
    parameter int KW    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DEPTH-1:0][AW-1:0]  ent_addr,
    input  logic [DEPTH-1:0][KW-1:0]  ent_key,
    input  logic [DEPTH-1:0]          ent_vld,
    input  logic [AW-1:0]             q_addr,
    input  logic [AW-1:0]             q_addr_hi,
    input  logic [KW-1:0]             q_key,
    output logic [DEPTH-1:0]          addr_hit,
    output logic [DEPTH-1:0]          sc_hit,
    output logic [DEPTH-1:0]          rng_hit
);
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            // one comparator slice per entry
            always_comb begin
                addr_hit[g] = ent_vld[g] && (ent_addr[g] == q_addr);
                sc_hit[g]   = addr_hit[g] && (ent_key[g] == q_key);
                rng_hit[g]  = ent_vld[g] && (ent_addr[g] >= q_addr) &&
                              (ent_addr[g] <= q_addr_hi);
            end
        end
    endgenerate

    // R3
    uniq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_hit));
endmodule

// File: rtl/llsc_key_alloc.sv
// Module: reservation key allocator. A counter that starts at 1 and
// advances on each allocation. It wraps from all-ones to 1, so 0 is never issued.
module llsc_key_alloc #(
    parameter int KW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    output logic [KW-1:0] key_cur
);
    localparam logic [KW-1:0] KEY_ONE = KW'(1);

    // advance the counter, skipping zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_cur <= KEY_ONE;
        else if (alloc)
            key_cur <= (key_cur == '1) ? KEY_ONE : key_cur + KEY_ONE;
    end

    // R4
    key_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_cur != '0);
endmodule

// File: rtl/llsc_victim.sv
// Module: chooses the slot for a new reservation. It prefers the lowest
// invalid entry and otherwise uses a round-robin pointer, which moves only
// when a valid entry is evicted.
module llsc_victim #(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ent_vld,
    input  logic             take,
    output logic [IW-1:0]    slot,
    output logic             all_valid
);
    logic [IW-1:0] rr_ptr;
    logic [IW-1:0] free_idx;

    // find the lowest invalid entry
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!ent_vld[i]) free_idx = IW'(i);
    end

    assign all_valid = &ent_vld;
    assign slot      = all_valid ? rr_ptr : free_idx;

    // advance the round-robin pointer after each eviction
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (take && all_valid)
            rr_ptr <= (rr_ptr == IW'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
    end

    // R8
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !all_valid |-> !ent_vld[slot]);
endmodule

// File: rtl/llsc_resv_ctrl.sv
// Module: top of the reservation controller. It holds the table, decodes one
// command per handshake and returns a single registered response beat.
// Assumes the data array acts on rsp_wr_en once the response is consumed.
module llsc_resv_ctrl
    import llsc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 40,
    parameter int KW    = 32,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [AW-1:0] cmd_addr_hi,
    input  logic [KW-1:0] cmd_key,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [KW-1:0] rsp_key,
    output logic          rsp_ok,
    output logic          rsp_wr_en
);
    logic [DEPTH-1:0][AW-1:0] t_addr;
    logic [DEPTH-1:0][KW-1:0] t_key;
    logic [DEPTH-1:0]         t_vld;
    logic [DEPTH-1:0]         addr_hit, sc_hit, rng_hit;
    logic [KW-1:0]            key_cur, hit_key;
    logic [IW-1:0]            slot;
    logic                     all_valid, accept, ll_miss, rsp_is_ll;
    llsc_op_e                 op;

    assign op        = llsc_op_e'(cmd_op);
    assign cmd_ready = !rsp_valid;
    assign accept    = cmd_valid && cmd_ready;
    assign ll_miss   = accept && (op == OP_LL) && !(|addr_hit);

    llsc_match #(.DEPTH(DEPTH), .AW(AW), .KW(KW)) u_match (
        .clk(clk), .rst_n(rst_n),
        .ent_addr(t_addr), .ent_key(t_key), .ent_vld(t_vld),
        .q_addr(cmd_addr), .q_addr_hi(cmd_addr_hi), .q_key(cmd_key),
        .addr_hit(addr_hit), .sc_hit(sc_hit), .rng_hit(rng_hit)
    );

    llsc_key_alloc #(.KW(KW)) u_keys (
        .clk(clk), .rst_n(rst_n), .alloc(ll_miss), .key_cur(key_cur)
    );

    llsc_victim #(.DEPTH(DEPTH)) u_victim (
        .clk(clk), .rst_n(rst_n), .ent_vld(t_vld), .take(ll_miss),
        .slot(slot), .all_valid(all_valid)
    );

    // select the key of the (single) address-matching entry
    always_comb begin
        hit_key = '0;
        for (int i = 0; i < DEPTH; i++)
            if (addr_hit[i]) hit_key = hit_key | t_key[i];
    end

    // table update: allocate on a linked-load miss, clear on a store-conditional hit or a write in range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_vld <= '0;
        end else if (accept) begin
            case (op)
                OP_LL: if (ll_miss) begin
                    t_vld[slot]  <= 1'b1;
                    t_addr[slot] <= cmd_addr;
                    t_key[slot]  <= key_cur;
                end
                OP_SC:   t_vld <= t_vld & ~sc_hit;
                OP_WR:   t_vld <= t_vld & ~rng_hit;
                default: ;
            endcase
        end
    end

    // response register: load on accept, hold until consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_key   <= '0;
            rsp_ok    <= 1'b0;
            rsp_wr_en <= 1'b0;
            rsp_is_ll <= 1'b0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_is_ll <= (op == OP_LL);
            case (op)
                OP_LL: begin
                    rsp_key   <= (|addr_hit) ? hit_key : key_cur;
                    rsp_ok    <= 1'b1;
                    rsp_wr_en <= 1'b0;
                end
                OP_SC: begin
                    rsp_key   <= '0;
                    rsp_ok    <= |sc_hit;
                    rsp_wr_en <= |sc_hit;
                end
                OP_WR: begin
                    rsp_key   <= '0;
                    rsp_ok    <= 1'b1;
                    rsp_wr_en <= 1'b1;
                end
                default: begin
                    rsp_key   <= '0;
                    rsp_ok    <= 1'b0;
                    rsp_wr_en <= 1'b0;
                end
            endcase
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R2
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    // R2
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_key) &&
        $stable(rsp_ok) && $stable(rsp_wr_en));
    // R4
    ll_key_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_is_ll |-> rsp_key != '0);
    // R7
    wr_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (op == OP_WR) |=> rsp_wr_en && rsp_ok);
    // R6
    sc_miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (op == OP_SC) && !(|sc_hit) |=> $stable(t_vld));
endmodule

// File: tb/tb_llsc_resv_ctrl.sv
// Directed bench for the reservation controller. There is one task per scenario,
// and each task checks its own results.
module tb_llsc_resv_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [39:0] cmd_addr = '0;
    logic [39:0] cmd_addr_hi = '0;
    logic [31:0] cmd_key = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_key;
    logic        rsp_ok;
    logic        rsp_wr_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] r_key;
    logic        r_ok, r_wr;
    int          r_lat;

    always #4 clk = ~clk;

    llsc_resv_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_addr_hi(cmd_addr_hi),
        .cmd_key(cmd_key), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_key(rsp_key), .rsp_ok(rsp_ok), .rsp_wr_en(rsp_wr_en)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // issue one command and capture its response; latency counted in cycles
    task automatic send(input logic [1:0] op, input logic [39:0] lo,
                        input logic [39:0] hi, input logic [31:0] key);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = lo; cmd_addr_hi = hi; cmd_key = key;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        r_lat = 0;
        @(negedge clk);
        while (!rsp_valid) begin r_lat++; @(negedge clk); end
        r_key = rsp_key; r_ok = rsp_ok; r_wr = rsp_wr_en;
    endtask

    task automatic ll(input logic [39:0] a, input logic [31:0] exp, input string tag);
        send(2'd0, a, '0, '0);
        check({tag, " key"}, r_key, exp);
        check({tag, " ok/wr"}, {30'd0, r_ok, r_wr}, 32'd2);
    endtask

    task automatic sc(input logic [39:0] a, input logic [31:0] k, input logic exp, input string tag);
        send(2'd1, a, '0, k);
        check({tag, " ok/wr"}, {30'd0, r_ok, r_wr}, exp ? 32'd3 : 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        sc(40'h100, 32'd1, 1'b0, "R1 first sc fails");
        check("R2 latency", r_lat, 0);
    endtask

    task automatic t_ll_alloc;
        ll(40'h100, 32'd1, "R4 first key");
        ll(40'h200, 32'd2, "R4 second key");
        ll(40'h100, 32'd1, "R3 hit returns key");
        ll(40'h300, 32'd3, "R3 no alloc on hit");
    endtask

    task automatic t_sc;
        sc(40'h200, 32'd9, 1'b0, "R6 wrong key");
        sc(40'h200, 32'd2, 1'b1, "R5 sc hit");
        sc(40'h200, 32'd2, 1'b0, "R5 consumed");
        sc(40'h300, 32'd1, 1'b0, "R6 key of other addr");
        ll(40'h400, 32'd4, "R8 refill free");
    endtask

    task automatic t_range;
        send(2'd2, 40'h300, 40'h400, '0);
        check("R7 write ok/wr", {30'd0, r_ok, r_wr}, 32'd3);
        sc(40'h300, 32'd3, 1'b0, "R7 low bound cleared");
        sc(40'h400, 32'd4, 1'b0, "R7 high bound cleared");
        sc(40'h100, 32'd1, 1'b1, "R7 outside kept");
    endtask

    task automatic t_evict;
        for (int i = 0; i < 8; i++)
            ll(40'h1000 + 40'(i * 16), 32'(5 + i), "R4 fill");
        ll(40'h2000, 32'd13, "R8 evict first");
        ll(40'h2100, 32'd14, "R8 evict second");
        sc(40'h1000, 32'd5, 1'b0, "R8 victim e0 gone");
        sc(40'h1010, 32'd6, 1'b0, "R8 victim e1 gone");
        sc(40'h1020, 32'd7, 1'b1, "R8 e2 kept");
        sc(40'h2000, 32'd13, 1'b1, "R8 new entry live");
        ll(40'h2100, 32'd14, "R3 hit after evict");
        ll(40'h3000, 32'd15, "R8 free slot e0");
        ll(40'h3100, 32'd16, "R8 free slot e2");
        ll(40'h4000, 32'd17, "R8 rr at e2");
        sc(40'h3000, 32'd15, 1'b1, "R8 e0 survives");
        sc(40'h3100, 32'd16, 1'b0, "R8 e2 evicted");
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        rsp_ready = 1'b0;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 40'h2100; cmd_key = '0;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 held valid", {31'd0, rsp_valid}, 32'd1);
        check("R2 ready low", {31'd0, cmd_ready}, 32'd0);
        check("R2 held key", rsp_key, 32'd14);
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R2 released", {31'd0, rsp_valid}, 32'd0);
        send(2'd3, 40'h2100, 40'h2100, 32'd14);
        check("R9 reserved rsp", {r_key[29:0], r_ok, r_wr}, 32'd0);
        ll(40'h2100, 32'd14, "R9 table untouched");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                t_reset;
                t_ll_alloc;
                t_sc;
                t_range;
                t_evict;
                t_backpressure;
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule